// File: doc/BRIEF.md
# Clamped DAC sample summing junction

This block builds one DAC sample per clock from three signed 16-bit streams: a DC offset stream, the in-phase output of the channel's own up-converter, and the quadrature output of the paired (buddy) channel's up-converter. Each of the last two is gated by its own enable bit. The sum is formed at 18 bits, so that no intermediate result can wrap. It is then saturated between a programmable lower bound and a programmable upper bound, and registered.

A second pair of saturating limiters, built from the same clamp, bounds the I and Q samples that feed the up-converter. Both lanes use one common, separately programmed pair of bounds. The buddy quadrature path is present at the ports but is disabled by default (`Q_PATH_EN = 0`). In that state the quadrature term never reaches the sum, whatever its enable bit holds.

Settings are written through a small word-wide write port. Each write lands at a clock edge and governs the samples from the following edge on.

Top module: `dac_sum_clamp`

## Requirements
- R1: While reset is held, `dac_o`, `lim_i_o` and `lim_q_o` are 0. After reset, both bound pairs are +32767 / -32767, the in-phase enable is 1 and the quadrature enable is 0.
- R2: With the in-phase enable set and the bounds not reached, `dac_o` equals `offset_i + upc_i_i` one clock after those inputs are sampled.
- R3: Writing address 0 with bit 0 clear removes `upc_i_i` from the sum. Writing bit 0 set restores it.
- R4: With the default `Q_PATH_EN = 0`, neither `buddy_q_i` nor the quadrature enable (address 0, bit 1) has any effect on `dac_o`.
- R5: The sum never wraps. For example, 32767 + 32767 yields the upper bound, and -32768 + -32768 yields the lower bound.
- R6: `dac_o` never exceeds the output upper bound (address 3) and, when that bound is not below the output lower bound (address 4), never falls below the lower bound. Both bounds are independent signed 16-bit values.
- R7: If the programmed lower bound is greater than the upper bound, `dac_o` equals the upper bound.
- R8: `lim_i_o` and `lim_q_o` are `lim_i_i` and `lim_q_i`, registered one clock and clamped to the shared bounds at address 1 (upper) and address 2 (lower).
- R9: A write presented at one clock edge does not change the sample produced at that edge. It governs every sample from the next edge onward.
- R10: Writes to addresses 5, 6 and 7 change no setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Setting write strobe |
| cfg_addr_i | input | 3 | Setting address (0 enables, 1/2 pre bounds hi/lo, 3/4 output bounds hi/lo) |
| cfg_wdata_i | input | 16 | Setting value (bounds signed; address 0 bit 0 in-phase, bit 1 quadrature) |
| offset_i | input | 16 | Signed offset stream |
| upc_i_i | input | 16 | Signed in-phase up-converter output of this channel |
| buddy_q_i | input | 16 | Signed quadrature up-converter output of the buddy channel |
| lim_i_i | input | 16 | Signed I sample entering the up-converter |
| lim_q_i | input | 16 | Signed Q sample entering the up-converter |
| dac_o | output | 16 | Registered, clamped DAC sample |
| lim_i_o | output | 16 | Registered, clamped I sample |
| lim_q_o | output | 16 | Registered, clamped Q sample |

## Verification
The hardest situation to reach is an inverted bound pair: the lower bound raised above the upper one while samples fall below, between and above both values. The bench gets there by first lowering the upper bound and then writing a larger lower bound, after which it sweeps the offset across all three regions. Saturation of a sum that would wrap at 16 bits needs both addends at extreme codes together, so directed full-scale pairs precede a long randomized phase that mixes random writes to all eight addresses with random samples.

// File: rtl/sumlim_pkg.sv
package sumlim_pkg;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned LANES  = 2;

  typedef enum logic [2:0] {
    ADDR_EN     = 3'd0,
    ADDR_PRE_HI = 3'd1,
    ADDR_PRE_LO = 3'd2,
    ADDR_OUT_HI = 3'd3,
    ADDR_OUT_LO = 3'd4
  } cfg_addr_e;

  localparam int unsigned ADDR_W = $bits(cfg_addr_e);
endpackage

// File: rtl/sumlim_cfg.sv
module sumlim_cfg
  import sumlim_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [DW-1:0]        wdata_i,
  output logic                 i_en_o,
  output logic                 q_en_o,
  output logic signed [DW-1:0] pre_hi_o,
  output logic signed [DW-1:0] pre_lo_o,
  output logic signed [DW-1:0] out_hi_o,
  output logic signed [DW-1:0] out_lo_o
);
  localparam logic signed [DW-1:0] POS_FS = {1'b0, {(DW-1){1'b1}}};
  localparam logic signed [DW-1:0] NEG_FS = {1'b1, {(DW-2){1'b0}}, 1'b1};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      i_en_o   <= 1'b1;
      q_en_o   <= 1'b0;
      pre_hi_o <= POS_FS;
      pre_lo_o <= NEG_FS;
      out_hi_o <= POS_FS;
      out_lo_o <= NEG_FS;
    end else if (we_i) begin
      case (cfg_addr_e'(addr_i))
        ADDR_EN: begin
          i_en_o <= wdata_i[0];
          q_en_o <= wdata_i[1];
        end
        ADDR_PRE_HI: pre_hi_o <= $signed(wdata_i);
        ADDR_PRE_LO: pre_lo_o <= $signed(wdata_i);
        ADDR_OUT_HI: out_hi_o <= $signed(wdata_i);
        ADDR_OUT_LO: out_lo_o <= $signed(wdata_i);
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/sumlim_gated_sum.sv
module sumlim_gated_sum #(
  parameter int unsigned DW        = 16,
  parameter int unsigned SW        = DW + 2,
  parameter bit          Q_PATH_EN = 1'b0
) (
  input  logic signed [DW-1:0] offset_i,
  input  logic signed [DW-1:0] upc_i_i,
  input  logic signed [DW-1:0] buddy_q_i,
  input  logic                 i_en_i,
  input  logic                 q_en_i,
  output logic signed [SW-1:0] sum_o
);
  logic signed [SW-1:0] off_x, i_term, q_term;

  assign off_x  = SW'(offset_i);
  assign i_term = i_en_i ? SW'(upc_i_i) : '0;

  generate
    if (Q_PATH_EN) begin : g_q_on
      assign q_term = q_en_i ? SW'(buddy_q_i) : '0;
    end else begin : g_q_off
      // quadrature path parked: inputs consumed only to keep lint quiet
      logic unused_q;
      assign unused_q = ^{buddy_q_i, q_en_i};
      assign q_term   = '0;
    end
  endgenerate

  assign sum_o = off_x + i_term + q_term;
endmodule

// File: rtl/sumlim_sat.sv
module sumlim_sat #(
  parameter int unsigned IN_W  = 18,
  parameter int unsigned OUT_W = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic signed [IN_W-1:0]  val_i,
  input  logic signed [OUT_W-1:0] lo_i,
  input  logic signed [OUT_W-1:0] hi_i,
  output logic signed [OUT_W-1:0] val_o
);
  logic signed [IN_W-1:0] lo_x, hi_x, floor_v, res_v;

  assign lo_x = IN_W'(lo_i);
  assign hi_x = IN_W'(hi_i);

  // floor first, ceiling last: an inverted pair resolves to the ceiling
  assign floor_v = (val_i < lo_x) ? lo_x : val_i;
  assign res_v   = (floor_v > hi_x) ? hi_x : floor_v;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) val_o <= '0;
    else         val_o <= res_v[OUT_W-1:0];
  end
endmodule

// File: rtl/dac_sum_clamp.sv
module dac_sum_clamp
  import sumlim_pkg::*;
#(
  parameter int unsigned DW        = sumlim_pkg::DATA_W,
  parameter bit          Q_PATH_EN = 1'b0
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cfg_we_i,
  input  logic [2:0]           cfg_addr_i,
  input  logic [DW-1:0]        cfg_wdata_i,
  input  logic signed [DW-1:0] offset_i,
  input  logic signed [DW-1:0] upc_i_i,
  input  logic signed [DW-1:0] buddy_q_i,
  input  logic signed [DW-1:0] lim_i_i,
  input  logic signed [DW-1:0] lim_q_i,
  output logic signed [DW-1:0] dac_o,
  output logic signed [DW-1:0] lim_i_o,
  output logic signed [DW-1:0] lim_q_o
);
  localparam int unsigned SW = DW + 2;

  logic                 i_en, q_en;
  logic signed [DW-1:0] pre_hi, pre_lo, out_hi, out_lo;
  logic signed [SW-1:0] sum;
  logic signed [DW-1:0] pre_in  [LANES];
  logic signed [DW-1:0] pre_out [LANES];

  sumlim_cfg #(.DW(DW)) u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (cfg_we_i),
    .addr_i   (cfg_addr_i),
    .wdata_i  (cfg_wdata_i),
    .i_en_o   (i_en),
    .q_en_o   (q_en),
    .pre_hi_o (pre_hi),
    .pre_lo_o (pre_lo),
    .out_hi_o (out_hi),
    .out_lo_o (out_lo)
  );

  sumlim_gated_sum #(.DW(DW), .SW(SW), .Q_PATH_EN(Q_PATH_EN)) u_sum (
    .offset_i  (offset_i),
    .upc_i_i   (upc_i_i),
    .buddy_q_i (buddy_q_i),
    .i_en_i    (i_en),
    .q_en_i    (q_en),
    .sum_o     (sum)
  );

  sumlim_sat #(.IN_W(SW), .OUT_W(DW)) u_out_sat (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .val_i  (sum),
    .lo_i   (out_lo),
    .hi_i   (out_hi),
    .val_o  (dac_o)
  );

  assign pre_in[0] = lim_i_i;
  assign pre_in[1] = lim_q_i;

  for (genvar k = 0; k < LANES; k++) begin : g_pre
    sumlim_sat #(.IN_W(DW), .OUT_W(DW)) u_pre_sat (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .val_i  (pre_in[k]),
      .lo_i   (pre_lo),
      .hi_i   (pre_hi),
      .val_o  (pre_out[k])
    );
  end

  assign lim_i_o = pre_out[0];
  assign lim_q_o = pre_out[1];
endmodule

// File: rtl/dac_sum_clamp_chk.sv
module dac_sum_clamp_chk #(
  parameter int unsigned DW        = 16,
  parameter bit          Q_PATH_EN = 1'b0
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic signed [DW-1:0] offset_i,
  input logic signed [DW-1:0] upc_i_i,
  input logic                 i_en,
  input logic signed [DW-1:0] pre_hi,
  input logic signed [DW-1:0] pre_lo,
  input logic signed [DW-1:0] out_hi,
  input logic signed [DW-1:0] out_lo,
  input logic signed [DW-1:0] dac_o,
  input logic signed [DW-1:0] lim_i_o,
  input logic signed [DW-1:0] lim_q_o
);
  a_r6_upper: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dac_o <= $past(out_hi));

  a_r6_lower: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(out_lo) <= $past(out_hi)) |-> (dac_o >= $past(out_lo)));

  a_r7_inverted: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(out_lo) > $past(out_hi)) |-> (dac_o == $past(out_hi)));

  a_r8_pre_upper: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lim_i_o <= $past(pre_hi)) && (lim_q_o <= $past(pre_hi)));

  a_r8_pre_lower: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(pre_lo) <= $past(pre_hi)) |->
      ((lim_i_o >= $past(pre_lo)) && (lim_q_o >= $past(pre_lo))));

  generate
    if (!Q_PATH_EN) begin : g_q_off
      // buddy data is left out of the antecedent on purpose
      a_r4_buddy_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(rst_ni) && $stable(offset_i) && $stable(upc_i_i) && $stable(i_en) &&
         $stable(out_hi) && $stable(out_lo)) |=> $stable(dac_o));
    end
  endgenerate
endmodule

bind dac_sum_clamp dac_sum_clamp_chk #(.DW(DW), .Q_PATH_EN(Q_PATH_EN)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .offset_i (offset_i),
  .upc_i_i  (upc_i_i),
  .i_en     (i_en),
  .pre_hi   (pre_hi),
  .pre_lo   (pre_lo),
  .out_hi   (out_hi),
  .out_lo   (out_lo),
  .dac_o    (dac_o),
  .lim_i_o  (lim_i_o),
  .lim_q_o  (lim_q_o)
);

// File: tb/dac_sum_clamp_bench.sv
`timescale 1ns/1ps
module dac_sum_clamp_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic we = 1'b0;
  logic [2:0] addr = '0;
  logic [15:0] wdata = '0;
  logic signed [15:0] offset = '0, upc = '0, buddy = '0, pi = '0, pq = '0;
  logic signed [15:0] dac, li, lq;

  int checks = 0, failures = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  dac_sum_clamp u_dac_sum_clamp (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_addr_i(addr), .cfg_wdata_i(wdata),
    .offset_i(offset), .upc_i_i(upc), .buddy_q_i(buddy), .lim_i_i(pi), .lim_q_i(pq),
    .dac_o(dac), .lim_i_o(li), .lim_q_o(lq)
  );

  // behavioural reference
  int m_ien, m_qen, m_pre_hi, m_pre_lo, m_out_hi, m_out_lo;
  int e_dac, e_li, e_lq;

  function automatic int clampv(int v, int lo, int hi);
    int r = v;
    if (r < lo) r = lo;
    if (r > hi) r = hi;
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ien = 1; m_qen = 0;
      m_pre_hi = 32767; m_pre_lo = -32767; m_out_hi = 32767; m_out_lo = -32767;
      e_dac = 0; e_li = 0; e_lq = 0;
    end else begin
      e_dac = clampv(int'(offset) + (m_ien != 0 ? int'(upc) : 0), m_out_lo, m_out_hi);
      e_li  = clampv(int'(pi), m_pre_lo, m_pre_hi);
      e_lq  = clampv(int'(pq), m_pre_lo, m_pre_hi);
      if (we) begin
        case (addr)
          3'd0: begin m_ien = int'(wdata[0]); m_qen = int'(wdata[1]); end
          3'd1: m_pre_hi = int'($signed(wdata));
          3'd2: m_pre_lo = int'($signed(wdata));
          3'd3: m_out_hi = int'($signed(wdata));
          3'd4: m_out_lo = int'($signed(wdata));
          default: ;
        endcase
      end
    end
  end

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", cur_req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    chk("dac_o", int'(dac), e_dac);
    chk("lim_i_o", int'(li), e_li);
    chk("lim_q_o", int'(lq), e_lq);
    we = 1'b0;
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    we = 1'b1; addr = a; wdata = d;
    tick();
  endtask

  task automatic feed(int off, int u);
    offset = 16'(off); upc = 16'(u);
    tick();
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    cur_req = "R1";
    repeat (2) @(negedge clk);
    chk("reset dac_o", int'(dac), 0);
    chk("reset lim_i_o", int'(li), 0);
    chk("reset lim_q_o", int'(lq), 0);
    rst_n = 1'b1;
    tick();
    chk("after reset dac_o", int'(dac), 0);

    cur_req = "R2";
    feed(100, 50);   chk("sum", int'(dac), 150);
    feed(-300, 20);  chk("sum", int'(dac), -280);

    cur_req = "R3";
    wr(3'd0, 16'h0000); chk("old enable still used", int'(dac), -280);
    tick();             chk("in-phase gated off", int'(dac), -300);
    wr(3'd0, 16'h0001);
    tick();             chk("in-phase back on", int'(dac), -280);

    cur_req = "R4";
    wr(3'd0, 16'h0003);
    buddy = 16'sd12000;  feed(10, 5); chk("buddy ignored", int'(dac), 15);
    buddy = -16'sd20000; tick();      chk("buddy ignored", int'(dac), 15);
    buddy = 16'sh7fff;   tick();      chk("buddy ignored", int'(dac), 15);
    wr(3'd0, 16'h0001);

    cur_req = "R5";
    feed(32767, 32767);   chk("positive saturate", int'(dac), 32767);
    feed(-32768, -32768); chk("negative saturate", int'(dac), -32767);
    feed(-32768, 0);      chk("min code floored", int'(dac), -32767);

    cur_req = "R6";
    wr(3'd3, 16'd1000);
    wr(3'd4, 16'hFF38);
    feed(5000, 0);  chk("upper bound", int'(dac), 1000);
    feed(-5000, 0); chk("lower bound", int'(dac), -200);
    feed(300, 0);   chk("inside bounds", int'(dac), 300);

    cur_req = "R7";
    wr(3'd4, 16'd2000);
    feed(0, 0);    chk("inverted below", int'(dac), 1000);
    feed(1500, 0); chk("inverted between", int'(dac), 1000);
    feed(5000, 0); chk("inverted above", int'(dac), 1000);

    cur_req = "R8";
    wr(3'd1, 16'd500);
    wr(3'd2, 16'hFD44);
    pi = 16'sd600; pq = -16'sd800; tick();
    chk("I upper", int'(li), 500); chk("Q lower", int'(lq), -700);
    pi = 16'sd100; pq = 16'sd32767; tick();
    chk("I inside", int'(li), 100); chk("Q upper", int'(lq), 500);

    cur_req = "R9";
    wr(3'd4, 16'h8001);
    wr(3'd3, 16'h7FFF);
    feed(400, 0);      chk("baseline", int'(dac), 400);
    wr(3'd3, 16'd50);  chk("write cycle uses old bound", int'(dac), 400);
    tick();            chk("next cycle uses new bound", int'(dac), 50);

    cur_req = "R10";
    wr(3'd3, 16'h7FFF);
    feed(100, 20);
    wr(3'd5, 16'd0);
    wr(3'd6, 16'd1);
    wr(3'd7, 16'h0000);
    tick(); chk("unused addresses ignored", int'(dac), 120);
    pi = 16'sd900; tick(); chk("pre bound kept", int'(li), 500);

    cur_req = "R6";
    for (int n = 0; n < 600; n++) begin
      offset = 16'($urandom); upc = 16'($urandom); buddy = 16'($urandom);
      pi = 16'($urandom); pq = 16'($urandom);
      if ($urandom_range(9) == 0) begin
        we = 1'b1; addr = 3'($urandom); wdata = 16'($urandom);
      end
      tick();
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule